// File: doc/BRIEF.md
# Clock-Stop Entry and Wake Controller

This block decides when a small processor core may drop into its low-power halted state, and when it may leave it again. Instruction decode raises a one-cycle stop request. The controller weighs that request against a mode bit, the level of an external hold pin and a pending 2 Hz flag. If the request is taken, the controller turns off the PLL enable, the oscillator enable and the core clock enable. It also forces every display and CMOS output drive low.

While halted, the block watches the hold pin and four general-purpose pins through two-flop synchronizers. It compares them against the levels it captured at the moment of entry. Pins whose direction bit marks them as outputs are left out of this comparison. A wake event turns the oscillator back on and starts a settling count of slow reference ticks. When the count is done, the core clock is re-enabled and a one-cycle resume strobe tells the core to advance its program counter by one, past the stop instruction.

The block runs on an always-on control clock. The oscillator and PLL are represented only by their enable outputs.

Top module: `clkstop_ctrl`

## Requirements
- R1: After reset the oscillator, PLL and core clock enables are 1, the resume strobe is 0, and one cycle after reset is released the display and CMOS outputs follow their drive inputs.
- R2: With the mode bit at 0, a stop request while the synchronized hold level is 0 enters the halted state. With the hold level at 1, the request is a no-operation: every enable stays 1 and no resume strobe appears.
- R3: With the mode bit at 1, a stop request enters the halted state whatever the hold level.
- R4: While the 2 Hz pending input is 1, a stop request is refused and behaves as a no-operation in either mode.
- R5: On the clock edge that accepts a request, the oscillator, PLL and core clock enables all go to 0 and every display and CMOS output is driven 0. These values hold until a wake event.
- R6: In mode 0 (the mode latched at entry), the halted state ends when hold becomes 1, or when any port pin whose direction bit is 0 (input) changes level.
- R7: In mode 1, any change of the hold level in either direction ends the halted state, as does a level change on any input port pin.
- R8: A port pin whose direction bit is 1 (output) never causes a wake, whatever its level does.
- R9: After a wake, the oscillator enable returns to 1 while the core clock, PLL and output drives stay off. They stay off for exactly SETTLE_TICKS reference-tick pulses. The core resumes on the edge that samples the last of these pulses.
- R10: The core resumes with a resume strobe that is 1 for exactly one cycle, on the same edge where the core clock enable returns to 1.
- R11: Pin levels that changed and settled before entry do not wake the block; only changes relative to the levels captured at entry count.
- R12: A stop request that arrives while the block is halted or settling is ignored. Settling completes normally and the core stays running afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on control clock |
| rst | input | 1 | Synchronous active-high reset |
| stop_req | input | 1 | One-cycle stop request from instruction decode |
| mode_sel | input | 1 | Stop mode: 0 gates entry on hold, 1 enters unconditionally |
| flag2hz_pend | input | 1 | 1 while the 2 Hz flag has not been cleared |
| hold_pin | input | 1 | Asynchronous hold pin |
| port_pin | input | NPORT | Asynchronous general-purpose pin levels |
| port_dir | input | NPORT | Per-pin direction, 1 = output (masked from wake) |
| ref_tick | input | 1 | One-cycle pulse per slow reference clock period |
| disp_in | input | NDISP | Display drive values from the core |
| cmos_in | input | NCMOS | CMOS port drive values from the core |
| osc_en | output | 1 | Oscillator enable |
| pll_en | output | 1 | PLL enable |
| core_clk_en | output | 1 | Core clock enable |
| resume_pulse | output | 1 | One-cycle strobe: core resumes at the next address |
| disp_out | output | NDISP | Gated display drives, 0 while halted |
| cmos_out | output | NCMOS | Gated CMOS drives, 0 while halted |

## Verification
The assertions check several rules on every cycle. A refused request, whether blocked by the 2 Hz flag or by a high hold in mode 0, leaves the core clock on. An accepted mode-1 request turns the oscillator off. The drives are low whenever the oscillator is off. The resume strobe lasts one cycle, follows a reference tick and coincides with the core clock coming back. The settle counter never passes its last value.

Some behaviours only the bench scenarios can show. The bench sweeps each port pin, each direction and each mode, and checks whether the wake fires or is masked. It also covers both hold edges in mode 1, the exact number of settling ticks, a pre-entry pin change that must not wake, and requests arriving while halted or settling.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;
  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_STOP   = 2'd1,
    ST_SETTLE = 2'd2
  } cs_state_e;
endpackage

// File: rtl/clkstop_sync.sv
module clkstop_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) pipe[0] <= '0;
          else     pipe[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) pipe[s] <= '0;
          else     pipe[s] <= pipe[s-1];
        end
      end
    end
  endgenerate

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/clkstop_wake.sv
module clkstop_wake #(
  parameter int NPORT = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             capture,
  input  logic             armed,
  input  logic             mode_in,
  input  logic             hold_s,
  input  logic [NPORT-1:0] port_s,
  input  logic [NPORT-1:0] port_dir,
  output logic             wake
);
  logic             mode_q;
  logic             hold_snap;
  logic [NPORT-1:0] port_snap;
  logic [NPORT-1:0] pin_evt;
  logic             hold_evt;

  // snapshot of levels and mode at the accepting edge
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= 1'b0;
      hold_snap <= 1'b0;
      port_snap <= '0;
    end else if (capture) begin
      mode_q    <= mode_in;
      hold_snap <= hold_s;
      port_snap <= port_s;
    end
  end

  genvar i;
  generate
    for (i = 0; i < NPORT; i++) begin : g_pin
      assign pin_evt[i] = ~port_dir[i] & (port_s[i] ^ port_snap[i]);
    end
  endgenerate

  always_comb begin
    if (mode_q) hold_evt = hold_s ^ hold_snap;
    else        hold_evt = hold_s;
  end

  assign wake = armed & (hold_evt | (|pin_evt));
endmodule

// File: rtl/clkstop_settle.sv
module clkstop_settle #(
  parameter int SETTLE_TICKS = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic active,
  input  logic tick,
  output logic done
);
  localparam int CW = (SETTLE_TICKS > 1) ? $clog2(SETTLE_TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(SETTLE_TICKS - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || start)         cnt <= '0;
    else if (active && tick)  cnt <= cnt + 1'b1;
  end

  assign done = active & tick & (cnt == LAST);

  AST_SETTLE_BOUND: assert property (@(posedge clk) disable iff (rst)
    active |-> (cnt <= LAST)); // R9
endmodule

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl #(
  parameter int NPORT        = 4,
  parameter int NDISP        = 8,
  parameter int NCMOS        = 4,
  parameter int SYNC_STAGES  = 2,
  parameter int SETTLE_TICKS = 100
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stop_req,
  input  logic             mode_sel,
  input  logic             flag2hz_pend,
  input  logic             hold_pin,
  input  logic [NPORT-1:0] port_pin,
  input  logic [NPORT-1:0] port_dir,
  input  logic             ref_tick,
  input  logic [NDISP-1:0] disp_in,
  input  logic [NCMOS-1:0] cmos_in,
  output logic             osc_en,
  output logic             pll_en,
  output logic             core_clk_en,
  output logic             resume_pulse,
  output logic [NDISP-1:0] disp_out,
  output logic [NCMOS-1:0] cmos_out
);
  import clkstop_pkg::*;

  localparam int SW = NPORT + 1;

  cs_state_e        state, state_nx;
  logic [SW-1:0]    pins_s;
  logic             hold_s;
  logic [NPORT-1:0] port_s;
  logic             accept, wake, settle_done;

  clkstop_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({hold_pin, port_pin}),
    .q   (pins_s)
  );
  assign hold_s = pins_s[SW-1];
  assign port_s = pins_s[NPORT-1:0];

  assign accept = (state == ST_RUN) & stop_req & ~flag2hz_pend & (mode_sel | ~hold_s);

  clkstop_wake #(.NPORT(NPORT)) u_wake (
    .clk      (clk),
    .rst      (rst),
    .capture  (accept),
    .armed    (state == ST_STOP),
    .mode_in  (mode_sel),
    .hold_s   (hold_s),
    .port_s   (port_s),
    .port_dir (port_dir),
    .wake     (wake)
  );

  clkstop_settle #(.SETTLE_TICKS(SETTLE_TICKS)) u_settle (
    .clk    (clk),
    .rst    (rst),
    .start  (wake),
    .active (state == ST_SETTLE),
    .tick   (ref_tick),
    .done   (settle_done)
  );

  always_comb begin
    state_nx = state;
    case (state)
      ST_RUN:    if (accept)      state_nx = ST_STOP;
      ST_STOP:   if (wake)        state_nx = ST_SETTLE;
      ST_SETTLE: if (settle_done) state_nx = ST_RUN;
      default:                    state_nx = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_RUN;
      osc_en       <= 1'b1;
      pll_en       <= 1'b1;
      core_clk_en  <= 1'b1;
      resume_pulse <= 1'b0;
      disp_out     <= '0;
      cmos_out     <= '0;
    end else begin
      state        <= state_nx;
      osc_en       <= (state_nx != ST_STOP);
      pll_en       <= (state_nx == ST_RUN);
      core_clk_en  <= (state_nx == ST_RUN);
      resume_pulse <= (state == ST_SETTLE) && (state_nx == ST_RUN);
      disp_out     <= (state_nx == ST_RUN) ? disp_in : '0;
      cmos_out     <= (state_nx == ST_RUN) ? cmos_in : '0;
    end
  end

  AST_FLAG_REFUSE: assert property (@(posedge clk) disable iff (rst)
    (core_clk_en && stop_req && flag2hz_pend) |=> core_clk_en); // R4
  AST_MODE0_HOLD_NOOP: assert property (@(posedge clk) disable iff (rst)
    (core_clk_en && stop_req && !mode_sel && hold_s) |=> core_clk_en); // R2
  AST_MODE1_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (core_clk_en && stop_req && mode_sel && !flag2hz_pend) |=> !osc_en); // R3
  AST_DRIVES_LOW: assert property (@(posedge clk) disable iff (rst)
    !osc_en |-> (disp_out == '0 && cmos_out == '0 && !pll_en)); // R5
  AST_RESUME_ONE: assert property (@(posedge clk) disable iff (rst)
    resume_pulse |=> !resume_pulse); // R10
  AST_RESUME_AFTER_TICK: assert property (@(posedge clk) disable iff (rst)
    resume_pulse |-> ($past(ref_tick) && core_clk_en)); // R9
  AST_CLK_BACK_RESUME: assert property (@(posedge clk) disable iff (rst)
    $rose(core_clk_en) |-> resume_pulse); // R10
endmodule

// File: tb/clkstop_ctrl_bench.sv
module clkstop_ctrl_bench;
  localparam int NPORT = 4;
  localparam int NDISP = 3;
  localparam int NCMOS = 2;
  localparam int TICKS = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stop_req = 1'b0, mode_sel = 1'b0, flag2hz_pend = 1'b0, hold_pin = 1'b0, ref_tick = 1'b0;
  logic [NPORT-1:0] port_pin = '0, port_dir = '0;
  logic [NDISP-1:0] disp_in = 3'b101;
  logic [NCMOS-1:0] cmos_in = 2'b11;
  logic osc_en, pll_en, core_clk_en, resume_pulse;
  logic [NDISP-1:0] disp_out;
  logic [NCMOS-1:0] cmos_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  clkstop_ctrl #(.NPORT(NPORT), .NDISP(NDISP), .NCMOS(NCMOS), .SYNC_STAGES(2),
                 .SETTLE_TICKS(TICKS)) u_clkstop_ctrl (
    .clk(clk), .rst(rst), .stop_req(stop_req), .mode_sel(mode_sel),
    .flag2hz_pend(flag2hz_pend), .hold_pin(hold_pin), .port_pin(port_pin),
    .port_dir(port_dir), .ref_tick(ref_tick), .disp_in(disp_in), .cmos_in(cmos_in),
    .osc_en(osc_en), .pll_en(pll_en), .core_clk_en(core_clk_en),
    .resume_pulse(resume_pulse), .disp_out(disp_out), .cmos_out(cmos_out)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_stop();
    stop_req = 1'b1;
    cyc(1);
    stop_req = 1'b0;
  endtask

  // halted state outputs: enables off, drives zero
  task automatic chk_halted(input string tag);
    chk({tag, " osc"}, osc_en, 0);
    chk({tag, " pll"}, pll_en, 0);
    chk({tag, " core"}, core_clk_en, 0);
    chk({tag, " disp"}, disp_out, 0);
    chk({tag, " cmos"}, cmos_out, 0);
  endtask

  task automatic chk_running(input string tag);
    chk({tag, " osc"}, osc_en, 1);
    chk({tag, " core"}, core_clk_en, 1);
    chk({tag, " resume"}, resume_pulse, 0);
    chk({tag, " disp"}, disp_out, int'(disp_in));
  endtask

  // issue TICKS reference pulses, check exact resume point
  task automatic run_settle(input string tag);
    chk({tag, " R9 osc on in settle"}, osc_en, 1);
    chk({tag, " R9 core off in settle"}, core_clk_en, 0);
    chk({tag, " R9 drives off in settle"}, disp_out, 0);
    for (int k = 0; k < TICKS - 1; k++) begin
      ref_tick = 1'b1; cyc(1); ref_tick = 1'b0; cyc(1);
    end
    chk({tag, " R9 still settling"}, core_clk_en, 0);
    ref_tick = 1'b1; cyc(1); ref_tick = 1'b0;
    chk({tag, " R9 core back"}, core_clk_en, 1);
    chk({tag, " R10 resume"}, resume_pulse, 1);
    chk({tag, " R9 pll back"}, pll_en, 1);
    cyc(1);
    chk({tag, " R10 resume one cycle"}, resume_pulse, 0);
  endtask

  initial begin
    cyc(3);
    rst = 1'b0;
    cyc(1);
    // R1 reset state
    chk("R1 osc", osc_en, 1);
    chk("R1 pll", pll_en, 1);
    chk("R1 core", core_clk_en, 1);
    chk("R1 resume", resume_pulse, 0);
    chk("R1 disp", disp_out, 5);
    chk("R1 cmos", cmos_out, 3);
    cyc(2);

    // R2 mode 0, hold high: no-op
    hold_pin = 1'b1; cyc(3);
    pulse_stop();
    chk_running("R2 hold high noop");
    cyc(2);
    chk_running("R2 hold high noop later");

    // R2/R6 mode 0, hold low: enter, wake on hold rising
    hold_pin = 1'b0; cyc(3);
    pulse_stop();
    chk_halted("R2 R5 mode0 entry");
    cyc(5);
    chk_halted("R5 mode0 held");
    hold_pin = 1'b1; cyc(3);
    chk("R6 hold rise wakes", osc_en, 1);
    run_settle("R6");
    hold_pin = 1'b0; cyc(3);

    // R4 flag pending refuses in both modes
    for (int m = 0; m < 2; m++) begin
      mode_sel = m[0]; flag2hz_pend = 1'b1;
      pulse_stop();
      chk_running("R4 flag refuse");
      cyc(2);
      chk("R4 no resume", resume_pulse, 0);
    end
    flag2hz_pend = 1'b0;

    // R3/R7 mode 1 entry with hold high, wake on hold falling
    mode_sel = 1'b1; hold_pin = 1'b1; cyc(3);
    pulse_stop();
    chk_halted("R3 mode1 hold high entry");
    mode_sel = 1'b0;  // latched mode must stay 1
    hold_pin = 1'b0; cyc(3);
    chk("R7 hold fall wakes", osc_en, 1);
    run_settle("R7 fall");
    // R3/R7 mode 1 entry with hold low, wake on rise
    mode_sel = 1'b1; cyc(1);
    pulse_stop();
    chk_halted("R3 mode1 hold low entry");
    hold_pin = 1'b1; cyc(3);
    chk("R7 hold rise wakes", osc_en, 1);
    run_settle("R7 rise");
    hold_pin = 1'b0; cyc(3);

    // R6/R7/R8 sweep: mode x pin x direction
    for (int m = 0; m < 2; m++) begin
      for (int i = 0; i < NPORT; i++) begin
        for (int d = 0; d < 2; d++) begin
          mode_sel = m[0];
          port_dir = (d == 1) ? NPORT'(1 << i) : '0;
          cyc(1);
          pulse_stop();
          chk_halted("R5 sweep entry");
          port_pin[i] = ~port_pin[i];
          cyc(3);
          if (d == 0) chk("R6 R7 input pin wakes", osc_en, 1);
          else        chk("R8 output pin masked", osc_en, 0);
          if (d == 1) begin
            cyc(4);
            chk("R8 output pin still masked", core_clk_en, 0);
            hold_pin = 1'b1; cyc(3);
          end
          run_settle("R6 R8 sweep");
          hold_pin = 1'b0; cyc(3);
        end
      end
    end
    port_dir = '0;

    // R11 settled pre-entry change must not wake
    mode_sel = 1'b1;
    port_pin[2] = ~port_pin[2]; cyc(5);
    pulse_stop();
    cyc(8);
    chk_halted("R11 pre-entry change ignored");

    // R12 request while halted, then while settling
    pulse_stop();
    cyc(2);
    chk("R12 request while halted", core_clk_en, 0);
    hold_pin = 1'b1; cyc(3);
    chk("R12 woke", osc_en, 1);
    pulse_stop();
    chk("R12 request in settle keeps osc", osc_en, 1);
    cyc(1);
    run_settle("R12");
    cyc(3);
    chk_running("R12 stays running");
    hold_pin = 1'b0;
    cyc(3);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule